// File: doc/BRIEF.md
# Ethernet Receive Pause Flow Controller

This block sits behind a receive MAC's control-frame parser. Each decoded control frame arrives as a single valid-qualified beat that carries the destination address, source address, EtherType, a 16-bit opcode and a packed parameter vector. The block matches the opcode against two configured values. One value selects link-level pause, which drives a single global request. The other selects per-priority pause, which drives one request per traffic class. Each channel has its own timer. A channel's request stays raised until the pause time it was given has elapsed.

Elapsed time is measured in 1/256 of a pause quantum, and one quantum is 512 bit times. On every cycle where the timing strobe `cfg_tick` is high, the channel subtracts the programmable step `cfg_step` from its remaining time. This lets the same logic serve any line rate and clock frequency: at 10 Gb/s with a 156.25 MHz clock the step is 32. A channel counts down only while the datapath acknowledges that it has actually paused.

Each channel is a small state machine with three states. `CH_IDLE` means no request. `CH_HOLD` means the request is raised but not yet acknowledged, so the count is frozen. `CH_RUN` means the request is acknowledged and the count is running. The transitions are as follows:
- `CH_IDLE`→`CH_HOLD` on a frame with a nonzero quanta value.
- `CH_HOLD`→`CH_RUN` when the acknowledge input is high.
- `CH_RUN`→`CH_HOLD` when the acknowledge input drops.
- `CH_RUN`→`CH_IDLE` when the remaining time is used up.
- From any state to `CH_IDLE` on a zero-quanta frame or when the channel enable is low.
- A nonzero frame in `CH_HOLD` or `CH_RUN` reloads the count and keeps the state.

Top module: `pause_rx_ctrl`

## Requirements
- R1: While `rst` is high, all channels go to `CH_IDLE` with zero count. After the first clock edge with `rst` high, `gl_req` and `cls_req` read 0.
- R2: A frame is a link-level pause frame when `cf_valid` is high, `cf_opcode` equals `cfg_gl_opcode`, `cfg_gl_on` is 1 and `gl_enable` is 1. Its quanta value is big-endian in parameter bytes 0 (high) and 1 (low), where byte i is `cf_params[8i+7:8i]`. A nonzero value raises `gl_req` in the cycle after the frame.
- R3: A channel in `CH_RUN` subtracts `cfg_step` from its remaining time (quanta×256) on each cycle where the acknowledge input and `cfg_tick` are both high. The request drops at the edge where the remaining time is at most the step. With acknowledge already high, a fresh frame keeps the request high for N+1 cycles, where N = ceil(quanta×256/step).
- R4: The remaining time does not change on cycles where `cfg_tick` is low or the acknowledge input is low.
- R5: A nonzero frame that arrives while a channel is counting reloads the channel with the new value. Measured from the cycle after that frame, the request then stays high for N cycles.
- R6: A frame with quanta value 0 for a channel sends it to `CH_IDLE`, so its request is low in the cycle after the frame.
- R7: A frame is a priority pause frame when `cf_opcode` equals `cfg_cls_opcode` and `cfg_cls_on` is 1. Bytes 0 and 1 hold a big-endian class-select vector whose bit c addresses class c. Class c's quanta value is big-endian in bytes 2+2c and 3+2c.
- R8: A priority frame whose select bit for class c is 0 leaves class c's state and remaining time unchanged.
- R9: A frame has no effect on a channel whose configuration enable (`cfg_gl_on`/`cfg_cls_on`) or runtime enable (`gl_enable`/`cls_enable[c]`) is low. If the runtime enable is low, the channel's request is low in the next cycle, even when the channel was active.
- R10: A frame whose opcode matches neither configured opcode changes no request. A link-level frame changes no class, and a priority frame does not change the link-level channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cf_valid | input | 1 | Control frame beat valid |
| cf_dst | input | 48 | Destination address (not decoded) |
| cf_src | input | 48 | Source address (not decoded) |
| cf_type | input | 16 | EtherType (not decoded) |
| cf_opcode | input | 16 | Control opcode |
| cf_params | input | PARAM_BYTES*8 | Parameter bytes, first byte in bits 7:0 |
| cfg_gl_opcode | input | 16 | Opcode for link-level pause |
| cfg_gl_on | input | 1 | Link-level pause handling enable |
| cfg_cls_opcode | input | 16 | Opcode for priority pause |
| cfg_cls_on | input | 1 | Priority pause handling enable |
| cfg_step | input | STEP_W | Time step per strobe, in 1/256 quantum |
| cfg_tick | input | 1 | Timing strobe |
| gl_enable | input | 1 | Link-level channel runtime enable |
| gl_ack | input | 1 | Link-level pause acknowledged |
| gl_req | output | 1 | Link-level pause request |
| cls_enable | input | NUM_CLASSES | Per-class runtime enables |
| cls_ack | input | NUM_CLASSES | Per-class pause acknowledges |
| cls_req | output | NUM_CLASSES | Per-class pause requests |

## Verification
Every result is one register stage away from its cause. A frame accepted at clock edge L shows on the request outputs right after L, and a release or an enable drop shows right after the next edge. An acknowledged fresh frame expires N+1 edges after L, and an in-flight reload expires N edges after its frame. The bench drives inputs and samples outputs on the falling edge. It counts how many consecutive falling-edge samples keep a request high, starting with the sample just after the frame's edge, and compares that count with the exact N+1 or N figure. For the all-class test it records the sample index at which each class drops. Freeze, release and isolation checks sample a fixed number of falling edges after the stimulus. This is always before the next stimulus, so a missed reload or a stray decrement shows up as an off-by-one count.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;

    // Per-channel pause timer states
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,   // no request
        CH_HOLD = 2'd1,   // request raised, waiting for acknowledge, count frozen
        CH_RUN  = 2'd2    // request acknowledged, counting down
    } chan_state_t;

    // Fraction bits below one quantum in the remaining-time counter
    localparam int FRAC_BITS = 8;

endpackage

// File: rtl/pause_frame_decode.sv
module pause_frame_decode #(
    parameter int PARAM_BYTES = 18,
    parameter int NUM_CLASSES = 8,
    parameter int QUANTA_W    = 16
) (
    input  logic                                 valid,
    input  logic [15:0]                          opcode,
    input  logic [PARAM_BYTES*8-1:0]             params,
    input  logic [15:0]                          cfg_gl_opcode,
    input  logic                                 cfg_gl_on,
    input  logic [15:0]                          cfg_cls_opcode,
    input  logic                                 cfg_cls_on,
    output logic                                 gl_load,
    output logic [QUANTA_W-1:0]                  gl_quanta,
    output logic [NUM_CLASSES-1:0]               cls_load,
    output logic [NUM_CLASSES-1:0][QUANTA_W-1:0] cls_quanta
);

    localparam int PARAM_W     = PARAM_BYTES * 8;
    localparam int FIELD_BYTES = QUANTA_W / 8;

    // Gather a big-endian field starting at byte offset 'first'
    function automatic logic [QUANTA_W-1:0] be_field(input logic [PARAM_W-1:0] v,
                                                     input int first);
        logic [QUANTA_W-1:0] f;
        f = '0;
        for (int b = 0; b < FIELD_BYTES; b++) begin
            f[QUANTA_W-1-8*b -: 8] = v[8*(first+b) +: 8];
        end
        return f;
    endfunction

    logic                gl_hit;
    logic                cls_hit;
    logic [QUANTA_W-1:0] class_sel;

    always_comb begin
        gl_hit    = valid && cfg_gl_on  && (opcode == cfg_gl_opcode);
        cls_hit   = valid && cfg_cls_on && (opcode == cfg_cls_opcode);
        class_sel = be_field(params, 0);
        gl_load   = gl_hit;
        gl_quanta = class_sel;   // link-level quanta shares the leading field
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        always_comb begin
            cls_load[c]   = cls_hit && class_sel[c];
            cls_quanta[c] = be_field(params, FIELD_BYTES * (c + 1));
        end
    end

endmodule

// File: rtl/pause_chan_timer.sv
module pause_chan_timer
    import pause_rx_pkg::*;
#(
    parameter int QUANTA_W = 16,
    parameter int STEP_W   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chan_en,
    input  logic                ack,
    input  logic                tick,
    input  logic [STEP_W-1:0]   step,
    input  logic                load,
    input  logic [QUANTA_W-1:0] quanta,
    output logic                req
);

    localparam int CNT_W = QUANTA_W + FRAC_BITS;

    chan_state_t      state_q, state_n;
    logic [CNT_W-1:0] count_q, count_n;
    logic [CNT_W-1:0] step_ext;

    assign step_ext = CNT_W'(step);

    // Next-state and next-count
    always_comb begin
        state_n = state_q;
        count_n = count_q;
        if (!chan_en) begin
            state_n = CH_IDLE;
            count_n = '0;
        end else if (load) begin
            if (quanta == '0) begin
                state_n = CH_IDLE;
                count_n = '0;
            end else begin
                count_n = {quanta, {FRAC_BITS{1'b0}}};
                state_n = (state_q == CH_RUN) ? CH_RUN : CH_HOLD;
            end
        end else begin
            unique case (state_q)
                CH_IDLE: ;
                CH_HOLD: begin
                    if (ack) state_n = CH_RUN;
                end
                CH_RUN: begin
                    if (!ack) begin
                        state_n = CH_HOLD;
                    end else if (tick) begin
                        if (count_q <= step_ext) begin
                            state_n = CH_IDLE;
                            count_n = '0;
                        end else begin
                            count_n = count_q - step_ext;
                        end
                    end
                end
                default: begin
                    state_n = CH_IDLE;
                    count_n = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_n;
            count_q <= count_n;
        end
    end

    // Outputs
    always_comb begin
        req = (state_q != CH_IDLE);
    end

    // R9: a disabled channel holds its request low
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !req);

    // R6: zero quanta releases the channel
    assert_zero_release_R6: assert property (@(posedge clk) disable iff (rst)
        (chan_en && load && quanta == '0) |=> !req);

    // R2 / R7: nonzero quanta raises the request
    assert_load_raises_R2: assert property (@(posedge clk) disable iff (rst)
        (chan_en && load && quanta != '0) |=> req);

    // R5: a load sets the full remaining time
    assert_reload_value_R5: assert property (@(posedge clk) disable iff (rst)
        (chan_en && load && quanta != '0) |=>
            count_q == {$past(quanta), {FRAC_BITS{1'b0}}});

    // R4: no progress without both acknowledge and strobe
    assert_frozen_count_R4: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !load && req && !(ack && tick)) |=> $stable(count_q));

    // R3: one step is consumed per strobe while counting
    assert_step_consumed_R3: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !load && state_q == CH_RUN && ack && tick && count_q > step_ext)
            |=> (count_q == $past(count_q) - $past(step_ext)) && req);

endmodule

// File: rtl/pause_rx_ctrl.sv
module pause_rx_ctrl #(
    parameter int PARAM_BYTES = 18,
    parameter int NUM_CLASSES = 8,
    parameter int QUANTA_W    = 16,
    parameter int STEP_W      = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cf_valid,
    input  logic [47:0]              cf_dst,
    input  logic [47:0]              cf_src,
    input  logic [15:0]              cf_type,
    input  logic [15:0]              cf_opcode,
    input  logic [PARAM_BYTES*8-1:0] cf_params,
    input  logic [15:0]              cfg_gl_opcode,
    input  logic                     cfg_gl_on,
    input  logic [15:0]              cfg_cls_opcode,
    input  logic                     cfg_cls_on,
    input  logic [STEP_W-1:0]        cfg_step,
    input  logic                     cfg_tick,
    input  logic                     gl_enable,
    input  logic                     gl_ack,
    output logic                     gl_req,
    input  logic [NUM_CLASSES-1:0]   cls_enable,
    input  logic [NUM_CLASSES-1:0]   cls_ack,
    output logic [NUM_CLASSES-1:0]   cls_req
);

    logic                                 gl_load;
    logic [QUANTA_W-1:0]                  gl_quanta;
    logic [NUM_CLASSES-1:0]               cls_load;
    logic [NUM_CLASSES-1:0][QUANTA_W-1:0] cls_quanta;

    // Address and type fields are carried but not decoded
    logic unused_hdr;
    assign unused_hdr = ^{cf_dst, cf_src, cf_type};

    pause_frame_decode #(
        .PARAM_BYTES (PARAM_BYTES),
        .NUM_CLASSES (NUM_CLASSES),
        .QUANTA_W    (QUANTA_W)
    ) u_decode (
        .valid          (cf_valid),
        .opcode         (cf_opcode),
        .params         (cf_params),
        .cfg_gl_opcode  (cfg_gl_opcode),
        .cfg_gl_on      (cfg_gl_on),
        .cfg_cls_opcode (cfg_cls_opcode),
        .cfg_cls_on     (cfg_cls_on),
        .gl_load        (gl_load),
        .gl_quanta      (gl_quanta),
        .cls_load       (cls_load),
        .cls_quanta     (cls_quanta)
    );

    pause_chan_timer #(
        .QUANTA_W (QUANTA_W),
        .STEP_W   (STEP_W)
    ) u_gl_timer (
        .clk     (clk),
        .rst     (rst),
        .chan_en (gl_enable),
        .ack     (gl_ack),
        .tick    (cfg_tick),
        .step    (cfg_step),
        .load    (gl_load),
        .quanta  (gl_quanta),
        .req     (gl_req)
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
        pause_chan_timer #(
            .QUANTA_W (QUANTA_W),
            .STEP_W   (STEP_W)
        ) u_cls_timer (
            .clk     (clk),
            .rst     (rst),
            .chan_en (cls_enable[c]),
            .ack     (cls_ack[c]),
            .tick    (cfg_tick),
            .step    (cfg_step),
            .load    (cls_load[c]),
            .quanta  (cls_quanta[c]),
            .req     (cls_req[c])
        );
    end

    // R10: a foreign opcode raises no idle link-level channel
    assert_foreign_gl_R10: assert property (@(posedge clk) disable iff (rst)
        (cf_valid && cf_opcode != cfg_gl_opcode && cf_opcode != cfg_cls_opcode && !gl_req)
            |=> !gl_req);

    // R10: a foreign opcode raises no idle class
    assert_foreign_cls_R10: assert property (@(posedge clk) disable iff (rst)
        (cf_valid && cf_opcode != cfg_gl_opcode && cf_opcode != cfg_cls_opcode && cls_req == '0)
            |=> cls_req == '0);

endmodule

// File: tb/test_pause_rx_ctrl.sv
module test_pause_rx_ctrl;

    localparam int NC = 8;
    localparam int PB = 18;
    localparam logic [15:0] OP_GL  = 16'h0001;
    localparam logic [15:0] OP_CLS = 16'h0101;

    logic            clk = 1'b0;
    logic            rst;
    logic            cf_valid;
    logic [47:0]     cf_dst, cf_src;
    logic [15:0]     cf_type, cf_opcode;
    logic [PB*8-1:0] cf_params;
    logic [15:0]     cfg_gl_opcode, cfg_cls_opcode;
    logic            cfg_gl_on, cfg_cls_on, cfg_tick;
    logic [9:0]      cfg_step;
    logic            gl_enable, gl_ack, gl_req;
    logic [NC-1:0]   cls_enable, cls_ack, cls_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] qv [NC];

    always #5 clk = ~clk;

    pause_rx_ctrl i_pause_rx_ctrl (
        .clk(clk), .rst(rst), .cf_valid(cf_valid), .cf_dst(cf_dst), .cf_src(cf_src),
        .cf_type(cf_type), .cf_opcode(cf_opcode), .cf_params(cf_params),
        .cfg_gl_opcode(cfg_gl_opcode), .cfg_gl_on(cfg_gl_on),
        .cfg_cls_opcode(cfg_cls_opcode), .cfg_cls_on(cfg_cls_on),
        .cfg_step(cfg_step), .cfg_tick(cfg_tick),
        .gl_enable(gl_enable), .gl_ack(gl_ack), .gl_req(gl_req),
        .cls_enable(cls_enable), .cls_ack(cls_ack), .cls_req(cls_req)
    );

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [PB*8-1:0] gl_params(logic [15:0] q);
        logic [PB*8-1:0] v = '0;
        v[7:0]  = q[15:8];
        v[15:8] = q[7:0];
        return v;
    endfunction

    function automatic logic [PB*8-1:0] cls_params(logic [15:0] sel);
        logic [PB*8-1:0] v = '0;
        v[7:0]  = sel[15:8];
        v[15:8] = sel[7:0];
        for (int c = 0; c < NC; c++) begin
            v[8*(2+2*c) +: 8] = qv[c][15:8];
            v[8*(3+2*c) +: 8] = qv[c][7:0];
        end
        return v;
    endfunction

    function automatic bit rq(int sel);
        return (sel == NC) ? gl_req : cls_req[sel];
    endfunction

    // Frame is taken at one rising edge; returns at the following falling edge
    task automatic send_frame(logic [15:0] op, logic [PB*8-1:0] p);
        @(negedge clk);
        cf_valid  = 1'b1;
        cf_opcode = op;
        cf_params = p;
        @(negedge clk);
        cf_valid  = 1'b0;
    endtask

    task automatic measure(int sel, output int n);
        n = 0;
        while (rq(sel) && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_qv();
        for (int c = 0; c < NC; c++) qv[c] = 16'd0;
    endtask

    task automatic t_reset();
        send_frame(OP_GL, gl_params(16'd50));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R1 gl_req after reset", gl_req, 0);
        check_eq("R1 cls_req after reset", cls_req, 0);
        rst = 1'b0;
        wait_n(2);
        check_eq("R1 gl_req idle after reset", gl_req, 0);
    endtask

    task automatic t_basic();
        int n;
        cfg_step = 10'd256;
        send_frame(OP_GL, gl_params(16'd5));
        check_eq("R2 gl_req raised", gl_req, 1);
        measure(NC, n);
        check_eq("R3 fresh duration q=5 step=256", n, 6);
        cfg_step = 10'd100;
        send_frame(OP_GL, gl_params(16'd1));
        measure(NC, n);
        check_eq("R3 fractional duration q=1 step=100", n, 4);
        cfg_step = 10'd32;
        send_frame(OP_GL, gl_params(16'd2));
        measure(NC, n);
        check_eq("R3 duration q=2 step=32", n, 17);
        cfg_step = 10'd256;
    endtask

    task automatic t_freeze();
        int n;
        cfg_tick = 1'b0;
        send_frame(OP_GL, gl_params(16'd2));
        wait_n(10);
        check_eq("R4 held while strobe low", gl_req, 1);
        cfg_tick = 1'b1;
        measure(NC, n);
        check_eq("R4 no time lost while strobe low", n, 2);
        gl_ack = 1'b0;
        send_frame(OP_GL, gl_params(16'd2));
        wait_n(10);
        check_eq("R4 held while ack low", gl_req, 1);
        gl_ack = 1'b1;
        measure(NC, n);
        check_eq("R4 countdown after ack", n, 3);
    endtask

    task automatic t_refresh_release();
        int n;
        send_frame(OP_GL, gl_params(16'd10));
        wait_n(5);
        send_frame(OP_GL, gl_params(16'd4));
        measure(NC, n);
        check_eq("R5 reload measured from new frame", n, 4);
        send_frame(OP_GL, gl_params(16'd50));
        wait_n(3);
        send_frame(OP_GL, gl_params(16'd0));
        check_eq("R6 zero quanta releases", gl_req, 0);
    endtask

    task automatic t_classes();
        int drop [NC];
        for (int c = 0; c < NC; c++) begin
            qv[c]   = 16'(c + 1);
            drop[c] = -1;
        end
        send_frame(OP_CLS, cls_params(16'h00FF));
        check_eq("R7 all classes raised", cls_req, 8'hFF);
        check_eq("R10 class frame leaves link idle", gl_req, 0);
        for (int t = 0; t < 30; t++) begin
            for (int c = 0; c < NC; c++)
                if (drop[c] < 0 && !cls_req[c]) drop[c] = t;
            @(negedge clk);
        end
        for (int c = 0; c < NC; c++)
            check_eq($sformatf("R7 class %0d drop sample", c), drop[c], c + 2);
    endtask

    task automatic t_isolation();
        int n;
        clear_qv();
        qv[0] = 16'd20;
        send_frame(OP_CLS, cls_params(16'h0001));
        wait_n(2);
        clear_qv();
        qv[1] = 16'd3;
        send_frame(OP_CLS, cls_params(16'h0002));
        measure(1, n);
        check_eq("R8 class 1 own duration", n, 4);
        check_eq("R8 class 0 untouched by class 1 frame", cls_req[0], 1);
        clear_qv();
        send_frame(OP_CLS, cls_params(16'h0001));
        check_eq("R6 class 0 released", cls_req, 0);
    endtask

    task automatic t_enables();
        cfg_gl_on = 1'b0;
        send_frame(OP_GL, gl_params(16'd5));
        check_eq("R9 link config off", gl_req, 0);
        cfg_gl_on = 1'b1;
        gl_enable = 1'b0;
        send_frame(OP_GL, gl_params(16'd5));
        check_eq("R9 link runtime off", gl_req, 0);
        gl_enable = 1'b1;
        send_frame(OP_GL, gl_params(16'd50));
        wait_n(2);
        gl_enable = 1'b0;
        @(negedge clk);
        check_eq("R9 enable drop clears active link", gl_req, 0);
        gl_enable = 1'b1;
        clear_qv();
        qv[0] = 16'd5;
        cls_enable = 8'hFE;
        send_frame(OP_CLS, cls_params(16'h0001));
        check_eq("R9 class runtime off", cls_req, 0);
        cls_enable = 8'hFF;
        cfg_cls_on = 1'b0;
        for (int c = 0; c < NC; c++) qv[c] = 16'd5;
        send_frame(OP_CLS, cls_params(16'h00FF));
        check_eq("R9 class config off", cls_req, 0);
        cfg_cls_on = 1'b1;
    endtask

    task automatic t_foreign();
        for (int c = 0; c < NC; c++) qv[c] = 16'd5;
        send_frame(16'h0102, cls_params(16'h00FF));
        wait_n(1);
        check_eq("R10 foreign opcode classes", cls_req, 0);
        check_eq("R10 foreign opcode link", gl_req, 0);
        send_frame(OP_GL, gl_params(16'd30));
        check_eq("R10 link frame leaves classes idle", cls_req, 0);
        send_frame(OP_GL, gl_params(16'd0));
        check_eq("R6 link release", gl_req, 0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cf_valid = 1'b0; cf_dst = 48'h0180C2000001; cf_src = 48'h5A5152535455;
        cf_type = 16'h8808; cf_opcode = '0; cf_params = '0;
        cfg_gl_opcode = OP_GL; cfg_cls_opcode = OP_CLS;
        cfg_gl_on = 1'b1; cfg_cls_on = 1'b1; cfg_tick = 1'b1; cfg_step = 10'd256;
        gl_enable = 1'b1; gl_ack = 1'b1; cls_enable = 8'hFF; cls_ack = 8'hFF;
        clear_qv();
        wait_n(3);
        check_eq("R1 gl_req in reset", gl_req, 0);
        check_eq("R1 cls_req in reset", cls_req, 0);
        rst = 1'b0;
        wait_n(2);
        t_basic();
        t_freeze();
        t_refresh_release();
        t_classes();
        t_isolation();
        t_enables();
        t_foreign();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule